// File: doc/BRIEF.md
# Zeroizable Master Key Store

This block keeps a 256-bit secret that can be wiped, and decides which master key goes downstream. A host loads the secret as eight 32-bit words through a plain register write/read port, or a hardware path loads all 256 bits in one cycle. A control register holds a usable flag for the secret, a bit that picks host or hardware loading, an ECC enable bit, and a 2-bit field that selects the master key.

The selected key is one of four things: the fused one-time key supplied on an input, the wipeable secret, the bitwise XOR of the two, or all zeros for the reserved code. A single-cycle zeroize pulse wipes the secret and drops its usable flag on the next clock edge. Mode, ECC enable and selection stay as they were. The secret words can never be read back over the host port.

Top module: `zkey_store`

## Requirements
- R1: After a synchronous active-low reset, all eight secret words, the usable flag, the mode bit, the ECC bit and the select field are 0.
- R2: Addresses 0 to 7 hold secret word i in key bits [32i+31:32i]. Address 8 is the control register: bit 0 usable flag, bit 1 mode (0 host, 1 hardware), bit 2 ECC enable, bits 5:4 select. A write takes effect on the clock edge that samples it.
- R3: Reads of addresses 0 to 7, and of any address above 8, return 0.
- R4: The key output equals the fused key when select is 0, the secret when select is 2, and fused XOR secret when select is 3. It is all zeros when select is 1.
- R5: In host mode, a control write sets or clears the usable flag from bit 0.
- R6: In hardware mode, host writes to addresses 0 to 7 are ignored, and bit 0 of a control write is ignored. The other control fields are still written.
- R7: In hardware mode, a hardware load pulse copies the 256-bit hardware key into the secret and sets the usable flag. In host mode the pulse is ignored.
- R8: A zeroize pulse clears all secret words and the usable flag at the next edge. It overrides host writes and hardware loads in the same cycle and leaves mode, ECC and select unchanged.
- R9: The ECC enable bit reads back at bit 2 and drives the ECC enable output. It has no effect on the key output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 4 | Host register address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from the address |
| hw_load | input | 1 | Hardware load pulse for the secret |
| hw_key | input | 256 | Key supplied by the hardware loading path |
| zeroize | input | 1 | Wipe request for secret and usable flag |
| fuse_key | input | 256 | Fused one-time key |
| key_o | output | 256 | Selected master key |
| key_valid_o | output | 1 | Usable flag of the secret |
| hw_mode_o | output | 1 | Current loading mode |
| ecc_en_o | output | 1 | ECC enable |

## Verification
A wrong secret word stays hidden from the read port. It shows on the key output only once select is 2 or 3, and it shows there in the same cycle. For that reason the bench sweeps the select values after every load, wipe and ignored write. A wrong usable flag, mode or select value shows at the control read and the status outputs one edge after the write that caused it. The bench compares every port against its own model at every cycle, so a fault is reported in the cycle it first becomes visible.

// File: rtl/zkey_pkg.sv
// Package: shared control field positions and key select codes.
// Assumes a 32-bit host data word; positions are fixed by the register map.
package zkey_pkg;
    localparam int CTL_VALID_BIT = 0;
    localparam int CTL_MODE_BIT  = 1;
    localparam int CTL_ECC_BIT   = 2;
    localparam int CTL_SEL_LO    = 4;

    typedef enum logic [1:0] {
        SEL_FUSED = 2'd0,
        SEL_RSVD  = 2'd1,
        SEL_WIPE  = 2'd2,
        SEL_MIXED = 2'd3
    } key_sel_e;
endpackage

// File: rtl/zkey_bank.sv
// Module: holds the wipeable secret as NUM_WORDS registers of WORD_W bits.
// Priority per word: reset, zeroize, hardware load (hardware mode),
// host write (host mode). Assumes hw_mode_i is the registered mode bit.
module zkey_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 4,
    localparam int KEY_W    = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    input  logic              hw_mode_i,
    input  logic              hw_load_i,
    input  logic [KEY_W-1:0]  hw_key_i,
    input  logic              zeroize_i,
    output logic [KEY_W-1:0]  key_q_o
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              host_hit;

        // Decode a host write to this word; only honoured in host mode.
        assign host_hit = bus_wr_i && !hw_mode_i && (bus_addr_i == ADDR_W'(i));

        // Update one secret word by the priority above.
        always_ff @(posedge clk) begin
            if (!rst_n)                      word_q <= '0;
            else if (zeroize_i)              word_q <= '0;
            else if (hw_mode_i && hw_load_i) word_q <= hw_key_i[i*WORD_W +: WORD_W];
            else if (host_hit)               word_q <= bus_wdata_i;
        end

        assign key_q_o[i*WORD_W +: WORD_W] = word_q;
    end

    // R8
    wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize_i |=> (key_q_o == '0));

    // R6
    hw_mode_host_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode_i && !hw_load_i && !zeroize_i) |=> $stable(key_q_o));
endmodule

// File: rtl/zkey_ctrl.sv
// Module: control register with usable flag, mode, ECC enable and select.
// Assumes ctrl_wr_i is already decoded for the control address. The usable
// flag is host-writable only in host mode, and is set by a hardware load in
// hardware mode.
module zkey_ctrl
    import zkey_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              hw_load_i,
    input  logic              zeroize_i,
    output logic              valid_o,
    output logic              hw_mode_o,
    output logic              ecc_en_o,
    output key_sel_e          sel_o
);
    logic valid_q, mode_q, ecc_q;
    key_sel_e sel_q;

    // Mode, ECC and select follow host control writes in any mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            ecc_q  <= 1'b0;
            sel_q  <= SEL_FUSED;
        end else if (ctrl_wr_i) begin
            mode_q <= wdata_i[CTL_MODE_BIT];
            ecc_q  <= wdata_i[CTL_ECC_BIT];
            sel_q  <= key_sel_e'(wdata_i[CTL_SEL_LO +: 2]);
        end
    end

    // Usable flag: wiped by zeroize, set by hardware load, host-written in host mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                          valid_q <= 1'b0;
        else if (zeroize_i)                  valid_q <= 1'b0;
        else if (mode_q && hw_load_i)        valid_q <= 1'b1;
        else if (!mode_q && ctrl_wr_i)       valid_q <= wdata_i[CTL_VALID_BIT];
    end

    assign valid_o   = valid_q;
    assign hw_mode_o = mode_q;
    assign ecc_en_o  = ecc_q;
    assign sel_o     = sel_q;

    // R8
    wipe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize_i |=> !valid_o);

    // R6
    hw_valid_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && hw_mode_o && !hw_load_i && !zeroize_i) |=> $stable(valid_o));

    // R7
    hw_load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode_o && hw_load_i && !zeroize_i) |=> valid_o);
endmodule

// File: rtl/zkey_mux.sv
// Module: picks the master key from the fused key and the secret.
// Assumes the select code comes from the control register; code 1 is reserved.
module zkey_mux
    import zkey_pkg::*;
#(
    parameter int KEY_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  key_sel_e         sel_i,
    input  logic [KEY_W-1:0] fused_i,
    input  logic [KEY_W-1:0] secret_i,
    output logic [KEY_W-1:0] key_o
);
    // Combine the two sources according to the select code.
    always_comb begin
        unique case (sel_i)
            SEL_FUSED: key_o = fused_i;
            SEL_WIPE:  key_o = secret_i;
            SEL_MIXED: key_o = fused_i ^ secret_i;
            default:   key_o = '0;
        endcase
    end

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_RSVD) |-> (key_o == '0));

    // R4
    mixed_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_MIXED) |-> ((key_o ^ secret_i) == fused_i));
endmodule

// File: rtl/zkey_store.sv
// Module: top of the wipeable master key store. Decodes the host port,
// hosts the secret bank, the control register and the output selector.
// Assumes a combinational read port and single-cycle write strobes.
module zkey_store
    import zkey_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 4,
    localparam int KEY_W    = WORD_W * NUM_WORDS,
    localparam int CTL_ADDR = NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              hw_load,
    input  logic [KEY_W-1:0]  hw_key,
    input  logic              zeroize,
    input  logic [KEY_W-1:0]  fuse_key,
    output logic [KEY_W-1:0]  key_o,
    output logic              key_valid_o,
    output logic              hw_mode_o,
    output logic              ecc_en_o
);
    logic [KEY_W-1:0] secret;
    logic             ctrl_wr;
    key_sel_e         sel;

    // Decode a host write to the control register.
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));

    zkey_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .hw_mode_i(hw_mode_o), .hw_load_i(hw_load),
        .hw_key_i(hw_key), .zeroize_i(zeroize), .key_q_o(secret)
    );

    zkey_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .wdata_i(bus_wdata),
        .hw_load_i(hw_load), .zeroize_i(zeroize), .valid_o(key_valid_o),
        .hw_mode_o(hw_mode_o), .ecc_en_o(ecc_en_o), .sel_o(sel)
    );

    zkey_mux #(.KEY_W(KEY_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .fused_i(fuse_key),
        .secret_i(secret), .key_o(key_o)
    );

    // Read port: only the control register is visible; secret words read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTL_ADDR)) begin
            bus_rdata[CTL_VALID_BIT]     = key_valid_o;
            bus_rdata[CTL_MODE_BIT]      = hw_mode_o;
            bus_rdata[CTL_ECC_BIT]       = ecc_en_o;
            bus_rdata[CTL_SEL_LO +: 2]   = sel;
        end
    end

    // R3
    secret_unreadable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(CTL_ADDR)) |-> (bus_rdata == '0));
endmodule

// File: tb/zkey_store_tb.sv
module zkey_store_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         hw_load = 1'b0;
    logic [255:0] hw_key = '0;
    logic         zeroize = 1'b0;
    logic [255:0] fuse_key = '0;
    logic [255:0] key_o;
    logic         key_valid_o, hw_mode_o, ecc_en_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    running = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [255:0] m_key;
    logic         m_valid, m_mode, m_ecc;
    logic [1:0]   m_sel;

    always #5 clk = ~clk;

    zkey_store u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_load(hw_load),
        .hw_key(hw_key), .zeroize(zeroize), .fuse_key(fuse_key), .key_o(key_o),
        .key_valid_o(key_valid_o), .hw_mode_o(hw_mode_o), .ecc_en_o(ecc_en_o)
    );

    // Behavioural model of R1, R2, R5-R8, updated on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_key = '0; m_valid = 0; m_mode = 0; m_ecc = 0; m_sel = 0;
        end else begin
            logic old_mode;
            old_mode = m_mode;
            if (bus_wr && bus_addr == 4'd8) begin
                m_mode = bus_wdata[1];
                m_ecc  = bus_wdata[2];
                m_sel  = bus_wdata[5:4];
            end
            if (zeroize) begin
                m_key = '0; m_valid = 0;
            end else if (old_mode && hw_load) begin
                m_key = hw_key; m_valid = 1;
            end else if (!old_mode) begin
                if (bus_wr && bus_addr < 4'd8) m_key[int'(bus_addr)*32 +: 32] = bus_wdata;
                if (bus_wr && bus_addr == 4'd8) m_valid = bus_wdata[0];
            end
        end
    end

    // Compare every port with the model away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            logic [255:0] ek;
            logic [31:0]  er;
            case (m_sel)
                2'd0: ek = fuse_key;
                2'd2: ek = m_key;
                2'd3: ek = fuse_key ^ m_key;
                default: ek = '0;
            endcase
            er = (bus_addr == 4'd8) ? {26'd0, m_sel, 1'b0, m_ecc, m_mode, m_valid} : 32'd0;
            n_chk++;
            if (key_o !== ek) begin
                n_fail++;
                $display("FAIL %s key_o act=%h exp=%h", cur_req, key_o, ek);
            end
            if (bus_rdata !== er) begin
                n_fail++;
                $display("FAIL %s rdata act=%h exp=%h", cur_req, bus_rdata, er);
            end
            if ({key_valid_o, hw_mode_o, ecc_en_o} !== {m_valid, m_mode, m_ecc}) begin
                n_fail++;
                $display("FAIL %s status act=%b exp=%b", cur_req,
                         {key_valid_o, hw_mode_o, ecc_en_o}, {m_valid, m_mode, m_ecc});
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
        bus_wr = 0; hw_load = 0; zeroize = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic rd(input logic [3:0] a);
        bus_addr = a;
        step();
    endtask

    // Select sweep: exposes the secret through R4 for each code.
    task automatic sweep(input logic ctl_hi);
        for (int s = 0; s < 4; s++) wr(4'd8, {26'd0, 2'(s), 2'b0, ctl_hi, 1'b0});
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            fuse_key[i*32 +: 32] = 32'hF00D_0000 + i;
            hw_key[i*32 +: 32]   = 32'h5A5A_1000 ^ (i * 32'h0101_0101);
        end
        repeat (2) @(posedge clk); #2;
        running = 1;
        // R1: reset values at the ports while reset is held
        cur_req = "R1"; rd(4'd8);
        rst_n = 1; rd(4'd8);
        // R2: host writes of all words, then R4 select sweep
        cur_req = "R2";
        for (int i = 0; i < 8; i++) wr(4'(i), 32'hA000_0000 | (32'h11 << i));
        cur_req = "R4"; sweep(1'b0);
        // R3: secret words and an unused address read back zero
        cur_req = "R3";
        for (int i = 0; i < 10; i++) rd(4'(i));
        rd(4'd15);
        // R5: host sets then clears the usable flag
        cur_req = "R5"; wr(4'd8, 32'h21); wr(4'd8, 32'h20); wr(4'd8, 32'h21);
        // R9: ECC bit on, key output unchanged
        cur_req = "R9"; wr(4'd8, 32'h25); rd(4'd8); wr(4'd8, 32'h31);
        // R7: hardware load in host mode is ignored
        cur_req = "R7"; hw_load = 1; step(); wr(4'd8, 32'h20);
        // R6: hardware mode ignores host key writes and the usable bit
        cur_req = "R6"; wr(4'd8, 32'h22);
        wr(4'd3, 32'hDEAD_BEEF); wr(4'd0, 32'h1234_5678);
        wr(4'd8, 32'h23); wr(4'd8, 32'h36);
        // R7: hardware load in hardware mode
        cur_req = "R7"; hw_load = 1; step(); sweep(1'b1);
        wr(4'd8, 32'h32);
        // R6: usable bit clear ignored in hardware mode
        cur_req = "R6"; wr(4'd8, 32'h22);
        // R8: zeroize wipes the secret, keeps mode and select
        cur_req = "R8"; zeroize = 1; step(); sweep(1'b1);
        // R8: zeroize beats a hardware load in the same cycle
        hw_load = 1; step(); wr(4'd8, 32'h32);
        hw_load = 1; zeroize = 1; step(); rd(4'd8);
        // R8: zeroize beats host writes in the same cycle (host mode)
        wr(4'd8, 32'h31); wr(4'd5, 32'hCAFE_F00D);
        zeroize = 1; bus_wr = 1; bus_addr = 4'd6; bus_wdata = 32'h7777_7777; step();
        zeroize = 1; bus_wr = 1; bus_addr = 4'd8; bus_wdata = 32'h35; step();
        sweep(1'b0);
        // R1: reset again after activity
        cur_req = "R1"; wr(4'd8, 32'h37); rst_n = 0; step(); rst_n = 1; rd(4'd8);
        running = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule